// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block is a small, fully associative cache of page translations that sits in front of a memory management unit. Each cycle it can accept one lookup: a virtual address, the number of the running process, and a read/write flag. The virtual address is split into a page number (upper bits) and an offset (lower `OFF_W` bits). Every stored entry is compared at once against the page number and the process number. On a hit, the physical address is formed from the stored frame number and the untouched offset. The result appears on registered outputs one cycle after the request.

Every entry carries the number of the process that owns it. Translations for several processes can therefore live side by side, and a context switch does not force the cache to be emptied. A flush input still clears every entry in one cycle.

The page-table side loads entries through a fill port. A fill takes a page number, a process number, a frame number, a write-permission bit and a dirty bit. Page-table walking and fault handling are left to the logic around the block.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid and `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_fault`, `rsp_paddr` and `rsp_dirty` are all 0. A lookup after reset reports a miss.
- R2: A lookup that matches a valid entry on both page number (`vaddr[VA_W-1:OFF_W]`) and process number reports `rsp_hit` one cycle after the request. `rsp_paddr` is then {frame, `vaddr[OFF_W-1:0]`}. With the defaults, address 1502 in page 1 at offset 478, filled with frame 5, translates to 5598.
- R3: A lookup that matches no valid entry reports `rsp_miss` with `rsp_paddr` = 0 and `rsp_dirty` = 0.
- R4: An entry matches only lookups that carry its own process number. Entries with the same page number and different process numbers coexist, and each returns its own frame.
- R5: A write lookup (`req_write`=1) that matches an entry whose write-permission bit is 0 reports `rsp_fault` instead of a hit, with `rsp_paddr` = 0. Read lookups to that entry hit, and writes to a permitted entry hit.
- R6: On a hit, `rsp_dirty` equals the dirty bit stored with the entry.
- R7: `flush` invalidates every entry and resets the replacement pointer to slot 0. A fill in the same cycle as a flush is dropped.
- R8: A fill whose page and process are not already present goes to the lowest-numbered invalid slot. When every slot is valid, it goes to the slot named by a replacement pointer. The pointer starts at 0, steps by one (wrapping) each time it is used, and otherwise holds still.
- R9: A fill whose page and process number match a valid entry overwrites that entry. No other entry is evicted.
- R10: A lookup in the same cycle as a fill sees the contents from before the fill. A lookup in the same cycle as a flush also sees the contents from before the flush.
- R11: When `rsp_valid` is 1, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is 1. When `rsp_valid` is 0, all three are 0 and `rsp_paddr` is 0. `rsp_valid` follows `req_valid` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_pid | input | PID_W | Process number of the requester |
| req_write | input | 1 | Lookup is a write access |
| fill_valid | input | 1 | Load one entry this cycle |
| fill_vpn | input | VA_W-OFF_W | Page number of the entry to load |
| fill_pid | input | PID_W | Owning process of the entry to load |
| fill_pfn | input | PA_W-OFF_W | Frame number of the entry to load |
| fill_wr_ok | input | 1 | Write permission of the entry to load |
| fill_dirty | input | 1 | Dirty bit of the entry to load |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | A lookup result is present |
| rsp_hit | output | 1 | Lookup translated |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Write to a write-protected entry |
| rsp_paddr | output | PA_W | Translated physical address, 0 unless hit |
| rsp_dirty | output | 1 | Dirty bit of the hit entry |

## Verification
State errors in this block show up at the response port one cycle after the lookup that reads the damaged entry. A lost valid bit or a wrong process tag turns an expected hit into a miss, or the reverse. A fill placed in the wrong slot evicts a translation that should have survived. The bench detects that only when it next looks up the page that should still be resident, so the eviction tests look up both the evicted page and a surviving page. A wrong frame or a wrong offset path shows up directly in `rsp_paddr`. A stale permission bit turns a hit into a fault.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_HIT   = 2'd1,
        RES_MISS  = 2'd2,
        RES_FAULT = 2'd3
    } res_e;

endpackage

// File: rtl/xlat_match.sv
// Parallel comparison of one key against every stored tag.
module xlat_match #(
    parameter int N     = 4,
    parameter int VPN_W = 6,
    parameter int PID_W = 4
) (
    input  logic [N-1:0]             valid,
    input  logic [N-1:0][VPN_W-1:0]  vpn_arr,
    input  logic [N-1:0][PID_W-1:0]  pid_arr,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [PID_W-1:0]         key_pid,
    output logic [N-1:0]             hit
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = valid[i] && (vpn_arr[i] == key_vpn) && (pid_arr[i] == key_pid);
    end

endmodule

// File: rtl/xlat_alloc.sv
// Picks the slot a fill is written to: matching entry, else first free, else victim.
module xlat_alloc #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     key_hit,
    input  logic [IDX_W-1:0] victim_ptr,
    output logic [IDX_W-1:0] slot,
    output logic             use_victim
);

    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        any_free = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (key_hit[i]) begin
                hit_idx = hit_idx | IDX_W'(i);
            end
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        use_victim = 1'b0;
        if (|key_hit) begin
            slot = hit_idx;
        end else if (any_free) begin
            slot = free_idx;
        end else begin
            slot       = victim_ptr;
            use_victim = 1'b1;
        end
    end

    // R8: with a free slot and no match, the chosen slot is an invalid one
    always_comb begin
        if (!(|key_hit) && !(&valid)) begin
            a_r8_free_slot_used: assert (!valid[slot]);
        end
    end

    // R9: a fill key matches at most one stored entry
    always_comb begin
        a_r9_single_match: assert ($onehot0(key_hit));
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int PA_W  = 16,
    parameter int OFF_W = 10,
    parameter int PID_W = 4,
    parameter int N     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [PID_W-1:0]      req_pid,
    input  logic                  req_write,
    input  logic                  fill_valid,
    input  logic [VA_W-OFF_W-1:0] fill_vpn,
    input  logic [PID_W-1:0]      fill_pid,
    input  logic [PA_W-OFF_W-1:0] fill_pfn,
    input  logic                  fill_wr_ok,
    input  logic                  fill_dirty,
    input  logic                  flush,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_miss,
    output logic                  rsp_fault,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  rsp_dirty
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]             valid;
        logic [N-1:0][VPN_W-1:0]  vpn_arr;
        logic [N-1:0][PID_W-1:0]  pid_arr;
        logic [N-1:0][PFN_W-1:0]  pfn_arr;
        logic [N-1:0]             wr_ok;
        logic [N-1:0]             dirty;
        logic [IDX_W-1:0]         ptr;
        logic                     r_valid;
        res_e                     r_res;
        logic [PA_W-1:0]          r_paddr;
        logic                     r_dirty;
    } state_t;

    state_t s_d, s_q;

    logic [N-1:0]     look_hit;
    logic [N-1:0]     fill_hit;
    logic [IDX_W-1:0] fill_slot;
    logic             fill_evict;
    logic [PFN_W-1:0] sel_pfn;
    logic             sel_wr_ok;
    logic             sel_dirty;

    xlat_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_look (
        .valid   (s_q.valid),
        .vpn_arr (s_q.vpn_arr),
        .pid_arr (s_q.pid_arr),
        .key_vpn (req_vaddr[VA_W-1:OFF_W]),
        .key_pid (req_pid),
        .hit     (look_hit)
    );

    xlat_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_fill (
        .valid   (s_q.valid),
        .vpn_arr (s_q.vpn_arr),
        .pid_arr (s_q.pid_arr),
        .key_vpn (fill_vpn),
        .key_pid (fill_pid),
        .hit     (fill_hit)
    );

    xlat_alloc #(.N(N), .IDX_W(IDX_W)) u_alloc (
        .valid      (s_q.valid),
        .key_hit    (fill_hit),
        .victim_ptr (s_q.ptr),
        .slot       (fill_slot),
        .use_victim (fill_evict)
    );

    always_comb begin
        sel_pfn   = '0;
        sel_wr_ok = 1'b0;
        sel_dirty = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (look_hit[i]) begin
                sel_pfn   = sel_pfn | s_q.pfn_arr[i];
                sel_wr_ok = sel_wr_ok | s_q.wr_ok[i];
                sel_dirty = sel_dirty | s_q.dirty[i];
            end
        end
    end

    always_comb begin
        s_d = s_q;

        // response path: reads the contents from before any update this cycle
        s_d.r_valid = req_valid;
        s_d.r_res   = RES_NONE;
        s_d.r_paddr = '0;
        s_d.r_dirty = 1'b0;
        if (req_valid) begin
            if (!(|look_hit)) begin
                s_d.r_res = RES_MISS;
            end else if (req_write && !sel_wr_ok) begin
                s_d.r_res = RES_FAULT;
            end else begin
                s_d.r_res   = RES_HIT;
                s_d.r_paddr = {sel_pfn, req_vaddr[OFF_W-1:0]};
                s_d.r_dirty = sel_dirty;
            end
        end

        // storage update: flush wins over fill
        if (flush) begin
            s_d.valid = '0;
            s_d.ptr   = '0;
        end else if (fill_valid) begin
            s_d.valid[fill_slot]   = 1'b1;
            s_d.vpn_arr[fill_slot] = fill_vpn;
            s_d.pid_arr[fill_slot] = fill_pid;
            s_d.pfn_arr[fill_slot] = fill_pfn;
            s_d.wr_ok[fill_slot]   = fill_wr_ok;
            s_d.dirty[fill_slot]   = fill_dirty;
            if (fill_evict) begin
                s_d.ptr = (s_q.ptr == IDX_W'(N - 1)) ? '0 : s_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.r_valid;
    assign rsp_hit   = (s_q.r_res == RES_HIT);
    assign rsp_miss  = (s_q.r_res == RES_MISS);
    assign rsp_fault = (s_q.r_res == RES_FAULT);
    assign rsp_paddr = s_q.r_paddr;
    assign rsp_dirty = s_q.r_dirty;

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r11_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_fault && rsp_paddr == '0));

    a_r4_unique_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_hit));

    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.valid == '0));

    a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr == '0 && !rsp_dirty));

    a_r5_fault_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> $past(req_write));

endmodule

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [15:0] req_vaddr;
    logic [3:0]  req_pid;
    logic        req_write;
    logic        fill_valid;
    logic [5:0]  fill_vpn;
    logic [3:0]  fill_pid;
    logic [5:0]  fill_pfn;
    logic        fill_wr_ok;
    logic        fill_dirty;
    logic        flush;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
    logic [15:0] rsp_paddr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xlat_cache #(.VA_W(16), .PA_W(16), .OFF_W(10), .PID_W(4), .N(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_pid(req_pid), .req_write(req_write),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_pfn(fill_pfn),
        .fill_wr_ok(fill_wr_ok), .fill_dirty(fill_dirty), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_dirty(rsp_dirty)
    );

    // expected result codes: 0 none, 1 hit, 2 miss, 3 fault
    typedef struct packed {
        logic        is_fill;
        logic [15:0] va;
        logic [3:0]  pid;
        logic        wr;
        logic [5:0]  pfn;
        logic        wok;
        logic        dty;
        logic [1:0]  exp;
        logic [15:0] epa;
        logic        edty;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'd1502, 4'd1, 1'b0, 6'd0, 1'b0, 1'b0, 2'd2, 16'd0,    1'b0, 4'd3}, // R3 empty
        '{1'b1, 16'd1024, 4'd1, 1'b0, 6'd5, 1'b1, 1'b0, 2'd0, 16'd0,    1'b0, 4'd8}, // R8 fill slot0
        '{1'b0, 16'd1502, 4'd1, 1'b0, 6'd0, 1'b0, 1'b0, 2'd1, 16'd5598, 1'b0, 4'd2}, // R2 page1 off478
        '{1'b0, 16'd1502, 4'd2, 1'b0, 6'd0, 1'b0, 1'b0, 2'd2, 16'd0,    1'b0, 4'd4}, // R4 other pid
        '{1'b1, 16'd1024, 4'd2, 1'b0, 6'd9, 1'b0, 1'b1, 2'd0, 16'd0,    1'b0, 4'd8}, // R8 fill slot1
        '{1'b0, 16'd1502, 4'd2, 1'b0, 6'd0, 1'b0, 1'b0, 2'd1, 16'd9694, 1'b1, 4'd6}, // R6 dirty, R4 coexist
        '{1'b0, 16'd1502, 4'd2, 1'b1, 6'd0, 1'b0, 1'b0, 2'd3, 16'd0,    1'b0, 4'd5}, // R5 fault
        '{1'b0, 16'd1502, 4'd1, 1'b1, 6'd0, 1'b0, 1'b0, 2'd1, 16'd5598, 1'b0, 4'd5}, // R5 permitted write
        '{1'b0, 16'd1023, 4'd1, 1'b0, 6'd0, 1'b0, 1'b0, 2'd2, 16'd0,    1'b0, 4'd3}  // R3 page0
    };

    task automatic idle_inputs();
        req_valid = 0; req_vaddr = '0; req_pid = '0; req_write = 0;
        fill_valid = 0; fill_vpn = '0; fill_pid = '0; fill_pfn = '0;
        fill_wr_ok = 0; fill_dirty = 0; flush = 0;
    endtask

    // one cycle: drive at negedge, registered result is visible at the next negedge
    task automatic cyc(input logic rv, input logic [15:0] va, input logic [3:0] pid, input logic wr,
                       input logic fv, input logic [5:0] fvpn, input logic [3:0] fpid,
                       input logic [5:0] fpfn, input logic fwok, input logic fdty, input logic fl);
        @(negedge clk);
        req_valid = rv; req_vaddr = va; req_pid = pid; req_write = wr;
        fill_valid = fv; fill_vpn = fvpn; fill_pid = fpid; fill_pfn = fpfn;
        fill_wr_ok = fwok; fill_dirty = fdty; flush = fl;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic chk(input logic [1:0] exp, input logic [15:0] epa, input logic edty, input int rq);
        logic [3:0] want;
        logic [3:0] got;
        want = {exp != 2'd0, exp == 2'd1, exp == 2'd2, exp == 2'd3};
        got  = {rsp_valid, rsp_hit, rsp_miss, rsp_fault};
        checks++;
        if (got !== want || rsp_paddr !== epa || rsp_dirty !== edty) begin
            errors++;
            $display("FAIL R%0d: got vhmf=%b pa=%0d d=%b exp vhmf=%b pa=%0d d=%b",
                     rq, got, rsp_paddr, rsp_dirty, want, epa, edty);
        end
    endtask

    task automatic look(input logic [15:0] va, input logic [3:0] pid, input logic wr,
                        input logic [1:0] exp, input logic [15:0] epa, input logic edty, input int rq);
        cyc(1'b1, va, pid, wr, 1'b0, 6'd0, 4'd0, 6'd0, 1'b0, 1'b0, 1'b0);
        chk(exp, epa, edty, rq);
    endtask

    task automatic fill(input logic [5:0] vpn, input logic [3:0] pid, input logic [5:0] pfn,
                        input logic wok, input logic dty);
        cyc(1'b0, 16'd0, 4'd0, 1'b0, 1'b1, vpn, pid, pfn, wok, dty, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(2'd0, 16'd0, 1'b0, 1);                      // R1 reset outputs
        look(16'd1502, 4'd1, 1'b0, 2'd2, 16'd0, 1'b0, 1); // R1 nothing valid

        for (int i = 0; i < NV; i++) begin
            cyc(!VEC[i].is_fill, VEC[i].va, VEC[i].pid, VEC[i].wr,
                VEC[i].is_fill, VEC[i].va[15:10], VEC[i].pid, VEC[i].pfn, VEC[i].wok, VEC[i].dty, 1'b0);
            chk(VEC[i].exp, VEC[i].epa, VEC[i].edty, int'(VEC[i].rq));
        end

        // R9: refill of an existing key overwrites in place
        fill(6'd1, 4'd1, 6'd7, 1'b1, 1'b0);
        look(16'd1502, 4'd1, 1'b0, 2'd1, 16'd7646, 1'b0, 9);
        look(16'd1502, 4'd2, 1'b0, 2'd1, 16'd9694, 1'b1, 9);

        // R8: fill remaining free slots, then round-robin victims from slot 0
        fill(6'd2, 4'd1, 6'd10, 1'b1, 1'b0);
        fill(6'd3, 4'd1, 6'd11, 1'b1, 1'b0);
        look(16'd1502, 4'd1, 1'b0, 2'd1, 16'd7646, 1'b0, 9);  // R9 nothing evicted
        fill(6'd4, 4'd1, 6'd12, 1'b1, 1'b0);                 // evicts slot0
        look(16'd1502, 4'd1, 1'b0, 2'd2, 16'd0, 1'b0, 8);
        look(16'd1502, 4'd2, 1'b0, 2'd1, 16'd9694, 1'b1, 8);
        fill(6'd5, 4'd1, 6'd13, 1'b1, 1'b0);                 // evicts slot1
        look(16'd1502, 4'd2, 1'b0, 2'd2, 16'd0, 1'b0, 8);
        look(16'd2053, 4'd1, 1'b0, 2'd1, 16'd10245, 1'b0, 8);

        // R10: lookup in the fill cycle sees old contents
        cyc(1'b1, 16'd6144, 4'd3, 1'b0, 1'b1, 6'd6, 4'd3, 6'd20, 1'b1, 1'b0, 1'b0);
        chk(2'd2, 16'd0, 1'b0, 10);
        look(16'd6144, 4'd3, 1'b0, 2'd1, 16'd20480, 1'b0, 10);

        // R7 / R10: lookup during flush sees old contents, then all gone
        cyc(1'b1, 16'd4096, 4'd1, 1'b0, 1'b0, 6'd0, 4'd0, 6'd0, 1'b0, 1'b0, 1'b1);
        chk(2'd1, 16'd12288, 1'b0, 10);
        look(16'd4096, 4'd1, 1'b0, 2'd2, 16'd0, 1'b0, 7);
        look(16'd6144, 4'd3, 1'b0, 2'd2, 16'd0, 1'b0, 7);

        // R7: fill together with flush is dropped
        cyc(1'b0, 16'd0, 4'd0, 1'b0, 1'b1, 6'd7, 4'd1, 6'd30, 1'b1, 1'b0, 1'b1);
        look(16'd7168, 4'd1, 1'b0, 2'd2, 16'd0, 1'b0, 7);
        fill(6'd7, 4'd1, 6'd30, 1'b1, 1'b0);
        look(16'd7168, 4'd1, 1'b0, 2'd1, 16'd30720, 1'b0, 7);

        // R11: idle cycle gives no result
        @(negedge clk);
        chk(2'd0, 16'd0, 1'b0, 11);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule